// File: doc/BRIEF.md
# MDIO Management Master

This block is the host side of a two-wire PHY management link. It produces the management clock (MDC) from the system clock and runs Clause 22 frames on the shared data line, which it drives and samples through separate output, output-enable and input signals. A single frame either reads one PHY register or writes one. A continuous scan mode re-reads one register in back-to-back frames, so that software can poll a PHY status register without issuing a command for every poll.

The host side is a set of plain strobed registers. One configuration word sets a management soft reset, a preamble-suppress mode and a 3-bit clock select. An address register holds the PHY and register numbers. A command word starts a single read or a scan. Writing the write-data port starts a write frame. Read data, a busy flag and a not-valid flag are level outputs. No path through the block carries a stream. Read data is a holding register that is overwritten at the end of each read frame, and there is no back-pressure: the host must sample `rdata` before the next read frame finishes.

Top module: `mdio_master`

## Requirements
- R1: After `rst_n` is released, `busy`, `not_valid`, `mdc`, `mdio_oe` and `rdata` are all 0. The clock select starts at code 7, the slowest setting. Preamble suppress and management reset both start cleared.
- R2: The MDC period is 8*N system clocks with a 50% duty cycle. N depends on the clock select: codes 0 and 1 give 4, code 2 gives 6, 3 gives 8, 4 gives 10, 5 gives 14, 6 gives 20 and 7 gives 28.
- R3: While management reset (`cfg_mgmt_rst`) is set, MDC stays low, `mdio_oe` is 0, a frame in progress is dropped within one cycle (`busy` goes 0), and commands are ignored.
- R4: With preamble suppress clear, a frame is 64 MDC cycles long. Its bits, sent MSB first, are: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, 2 turnaround bits, 16 data bits. `mdio_o` and `mdio_oe` change only when MDC falls.
- R5: With preamble suppress set, the 32 preamble ones are left out and the frame is 32 MDC cycles long.
- R6: Writing `wdata_wr` while idle starts a write frame. The master drives every bit, with turnaround 10 followed by the 16 write-data bits.
- R7: A read frame releases the line (`mdio_oe`=0) for the two turnaround bits and the 16 data bits. It samples `mdio_i` on each rising MDC edge of the data bits and loads the 16 bits, MSB first, into `rdata` at the end of the frame.
- R8: `busy` rises the cycle after a command is accepted. It falls on the same system-clock edge as the MDC rising edge of the frame's last bit.
- R9: While `busy` is 1, writes to the address register, write-data port and read or scan start commands are ignored, and the frame in flight keeps its original content.
- R10: A command with the scan bit set starts read frames that repeat back to back. `not_valid` is 1 from the scan start until the first result reaches `rdata`. A command with the scan bit clear, written during a scan, lets the current frame finish before `busy` falls, and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-assert, active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_mgmt_rst | input | 1 | Management soft reset |
| cfg_no_pre | input | 1 | Preamble suppress |
| cfg_clk_sel | input | 3 | MDC divisor select |
| addr_wr | input | 1 | Write strobe for the PHY/register address |
| addr_phy | input | 5 | PHY address |
| addr_reg | input | 5 | Register address |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_read | input | 1 | Start a single read frame |
| cmd_scan | input | 1 | Start (1) or stop (0) continuous scan |
| wdata_wr | input | 1 | Write-data strobe; starts a write frame |
| wdata | input | 16 | Data for the write frame |
| rdata | output | 16 | Last read result |
| busy | output | 1 | A frame is pending or running |
| not_valid | output | 1 | First scan result not yet available |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Some rules are checked by assertions on every cycle: the line output changes only on a falling-MDC strobe, MDC holds between divider strobes, MDC stays low and `busy` stays low under management reset, `busy` ends only on a rising-MDC strobe, the line is released during the turnaround and data bits of a read, and `not_valid` is raised only while a scan is running. Other behaviour can only be shown by the bench scenarios, which run frames against a PHY model and a recorder: the exact bit content and length of each frame, the measured MDC period for every select code, the read data assembled from the PHY's bits, the commands ignored while busy, and the way scan repeats and then stops.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 3;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
  localparam int DATA_POS  = FRAME_LEN - DATA_W;
  localparam int DIV_W     = 5;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_SHIFT} eng_state_e;

  // Divisor applied after the fixed prescaler (counted in prescaler ticks per half period).
  function automatic logic [DIV_W-1:0] sel_divisor(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0, 3'd1: sel_divisor = 5'd4;
      3'd2:       sel_divisor = 5'd6;
      3'd3:       sel_divisor = 5'd8;
      3'd4:       sel_divisor = 5'd10;
      3'd5:       sel_divisor = 5'd14;
      3'd6:       sel_divisor = 5'd20;
      default:    sel_divisor = 5'd28;
    endcase
  endfunction

  // Full 64-bit frame image, bit FRAME_LEN-1 goes out first.
  function automatic logic [FRAME_LEN-1:0] frame_image(
      input logic              is_rd,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad,
      input logic [DATA_W-1:0] data);
    frame_image = {{PRE_LEN{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, regad,
                   (is_rd ? 2'b11 : 2'b10), (is_rd ? {DATA_W{1'b1}} : data)};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int HALF_PRE = PRESCALE / 2;
  localparam int PRE_W    = (HALF_PRE > 1) ? $clog2(HALF_PRE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(HALF_PRE - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             tick;
  logic             toggle;

  assign div_last = sel_divisor(sel) - 5'd1;
  assign tick     = (pre_cnt == PRE_LAST);
  assign toggle   = tick && (div_cnt >= div_last);
  assign rise_stb = toggle && !mdc;
  assign fall_stb = toggle && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else if (mrst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) div_cnt <= toggle ? '0 : div_cnt + 1'b1;
      if (toggle) mdc <= ~mdc;
    end
  end

  a_r3_mdc_low_in_mgmt_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> !mdc);

  a_r2_mdc_moves_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    !(rise_stb || fall_stb) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              start,
  input  logic              start_rd,
  input  logic              no_pre,
  input  logic              cont,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_upd
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] SKIP_IDX = IDX_W'(PRE_LEN);

  eng_state_e           state;
  logic [FRAME_LEN-1:0] frame_q;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nxt_idx;
  logic [IDX_W-1:0]     first_idx;
  logic                 rd_q;
  logic                 npre_q;
  logic [DATA_W-1:0]    shreg;

  assign busy      = (state != ENG_IDLE);
  assign nxt_idx   = idx + 1'b1;
  assign first_idx = npre_q ? SKIP_IDX : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      frame_q <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      npre_q  <= 1'b0;
      shreg   <= '0;
      rd_data <= '0;
      rd_upd  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (mrst) begin
      state   <= ENG_IDLE;
      rd_upd  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      rd_upd <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            frame_q <= frame_image(start_rd, phy, regad, wdata);
            rd_q    <= start_rd;
            npre_q  <= no_pre;
            state   <= ENG_WAIT;
          end else if (fall_stb) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
          end
        end
        ENG_WAIT: begin
          if (fall_stb) begin
            state   <= ENG_SHIFT;
            idx     <= first_idx;
            mdio_o  <= frame_q[LAST_IDX - first_idx];
            mdio_oe <= 1'b1;
          end
        end
        default: begin
          if (fall_stb) begin
            idx     <= nxt_idx;
            mdio_o  <= frame_q[LAST_IDX - nxt_idx];
            mdio_oe <= !(rd_q && (nxt_idx >= TA_IDX));
          end else if (rise_stb) begin
            if (rd_q && (idx >= DATA_IDX)) shreg <= {shreg[DATA_W-2:0], mdio_i};
            if (idx == LAST_IDX) begin
              if (rd_q) begin
                rd_data <= {shreg[DATA_W-2:0], mdio_i};
                rd_upd  <= 1'b1;
              end
              state <= cont ? ENG_WAIT : ENG_IDLE;
            end
          end
        end
      endcase
    end
  end

  a_r4_line_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    !fall_stb |=> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r8_busy_ends_on_rise: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    $fell(busy) |-> $past(rise_stb));

  a_r7_read_line_released: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    (state == ENG_SHIFT && rd_q && rise_stb && idx >= TA_IDX) |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_mgmt_rst,
  input  logic              cfg_no_pre,
  input  logic [SEL_W-1:0]  cfg_clk_sel,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_phy,
  input  logic [ADDR_W-1:0] addr_reg,
  input  logic              cmd_wr,
  input  logic              cmd_read,
  input  logic              cmd_scan,
  input  logic              wdata_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              not_valid,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              mrst_q;
  logic              npre_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic              scan_on;
  logic              nv_q;
  logic              eng_busy;
  logic              accept;
  logic              start_pulse;
  logic              start_rd;
  logic              rise_stb;
  logic              fall_stb;
  logic              rd_upd;

  assign accept    = !eng_busy && !mrst_q;
  assign busy      = eng_busy;
  assign not_valid = nv_q;

  always_comb begin
    start_pulse = 1'b0;
    start_rd    = 1'b0;
    if (accept) begin
      if (cmd_wr && (cmd_read || cmd_scan)) begin
        start_pulse = 1'b1;
        start_rd    = 1'b1;
      end else if (wdata_wr) begin
        start_pulse = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrst_q <= 1'b0;
      npre_q <= 1'b0;
      sel_q  <= '1;
    end else if (cfg_wr) begin
      mrst_q <= cfg_mgmt_rst;
      npre_q <= cfg_no_pre;
      sel_q  <= cfg_clk_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q <= '0;
      reg_q <= '0;
    end else if (addr_wr && accept) begin
      phy_q <= addr_phy;
      reg_q <= addr_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_on <= 1'b0;
      nv_q    <= 1'b0;
    end else if (mrst_q) begin
      scan_on <= 1'b0;
      nv_q    <= 1'b0;
    end else begin
      if (rd_upd) nv_q <= 1'b0;
      if (accept && cmd_wr && cmd_scan) begin
        scan_on <= 1'b1;
        nv_q    <= 1'b1;
      end else if (eng_busy && cmd_wr && !cmd_scan && scan_on) begin
        scan_on <= 1'b0;
        nv_q    <= 1'b0;
      end
    end
  end

  mdio_mdc_gen #(.PRESCALE(PRESCALE)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrst     (mrst_q),
    .sel      (sel_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrst     (mrst_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .start    (start_pulse),
    .start_rd (start_rd),
    .no_pre   (npre_q),
    .cont     (scan_on),
    .phy      (phy_q),
    .regad    (reg_q),
    .wdata    (wdata),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rdata),
    .rd_upd   (rd_upd)
  );

  a_r3_mgmt_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_q |=> !busy);

  a_r10_not_valid_within_scan: assert property (@(posedge clk) disable iff (!rst_n)
    not_valid |-> scan_on);
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, cfg_mgmt_rst = 0, cfg_no_pre = 0;
  logic [2:0]  cfg_clk_sel = 3'd7;
  logic        addr_wr = 0;
  logic [4:0]  addr_phy = 0, addr_reg = 0;
  logic        cmd_wr = 0, cmd_read = 0, cmd_scan = 0;
  logic        wdata_wr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        busy, not_valid, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] phy_word = 16'h0;
  int rel_cnt = 0;
  bit rec_arm = 0, rec_live = 0;
  logic log_o [128];
  logic log_oe [128];
  int n_log = 0;
  realtime last_rise = 0.0;

  always #2.5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mgmt_rst(cfg_mgmt_rst),
    .cfg_no_pre(cfg_no_pre), .cfg_clk_sel(cfg_clk_sel), .addr_wr(addr_wr),
    .addr_phy(addr_phy), .addr_reg(addr_reg), .cmd_wr(cmd_wr), .cmd_read(cmd_read),
    .cmd_scan(cmd_scan), .wdata_wr(wdata_wr), .wdata(wdata), .rdata(rdata),
    .busy(busy), .not_valid(not_valid), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // PHY model: answers whenever the master releases the line.
  always @(negedge mdc) begin
    #1;
    if (mdio_oe) begin
      rel_cnt = 0;
      mdio_i  = 1'b1;
    end else begin
      if (rel_cnt < 100) rel_cnt++;
      if (rel_cnt == 1) mdio_i = 1'b1;
      else if (rel_cnt == 2) mdio_i = 1'b0;
      else if (rel_cnt <= 18) mdio_i = phy_word[18 - rel_cnt];
      else mdio_i = 1'b1;
    end
  end

  always @(negedge mdc) if (rec_arm) begin rec_live = 1; rec_arm = 0; end

  always @(posedge mdc) begin
    #1;
    if (rec_live && n_log < 128) begin
      log_o[n_log]  = mdio_o;
      log_oe[n_log] = mdio_oe;
      n_log++;
      last_rise = $realtime - 1.0;
    end
  end

  function automatic int div_n(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: return 4;
      3'd2: return 6;
      3'd3: return 8;
      3'd4: return 10;
      3'd5: return 14;
      3'd6: return 20;
      default: return 28;
    endcase
  endfunction

  function automatic logic [63:0] tb_frame(input bit rd, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input bit mr, input bit np, input logic [2:0] s);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_mgmt_rst = mr; cfg_no_pre = np; cfg_clk_sel = s;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic addr_write(input logic [4:0] p, input logic [4:0] r);
    @(posedge clk); #1;
    addr_wr = 1; addr_phy = p; addr_reg = r;
    @(posedge clk); #1;
    addr_wr = 0;
  endtask

  task automatic cmd_write(input bit rd, input bit sc);
    @(posedge clk); #1;
    cmd_wr = 1; cmd_read = rd; cmd_scan = sc;
    @(posedge clk); #1;
    cmd_wr = 0; cmd_read = 0; cmd_scan = 0;
  endtask

  task automatic data_write(input logic [15:0] d);
    @(posedge clk); #1;
    wdata_wr = 1; wdata = d;
    @(posedge clk); #1;
    wdata_wr = 0;
  endtask

  // Starts a frame and arms the recorder for its first falling MDC edge.
  task automatic launch(input bit rd, input logic [15:0] d);
    n_log = 0;
    if (rd) cmd_write(1, 0); else data_write(d);
    chk(busy === 1'b1, "R8", "busy after command", busy, 1);
    rec_arm = 1;
  endtask

  task automatic finish_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                              input logic [15:0] d, input bit np, input string req);
    logic [63:0] fv;
    int len;
    int err;
    realtime tf;
    fv  = tb_frame(rd, p, r, d);
    len = np ? 32 : 64;
    err = 0;
    @(negedge busy);
    tf = $realtime;
    #20;
    rec_live = 0;
    chk(n_log == len, np ? "R5" : "R4", "frame length in MDC cycles", n_log, len);
    for (int j = 0; j < len && j < n_log; j++) begin
      int k;
      bit eoe;
      k   = (np ? 32 : 0) + j;
      eoe = !(rd && k >= 46);
      if (log_oe[j] !== eoe) err++;
      else if (eoe && log_o[j] !== fv[63 - k]) err++;
    end
    chk(err == 0, req, "frame bit or enable mismatches", err, 0);
    chk((tf - last_rise) < 0.01 && (last_rise - tf) < 0.01, "R8",
        "busy fall on last rising MDC (ns)", longint'(tf), longint'(last_rise));
    if (rd) chk(rdata === phy_word, "R7", "read data", rdata, phy_word);
  endtask

  task automatic measure(input logic [2:0] s, input string req);
    realtime t0, t1, t2;
    int n;
    n = div_n(s);
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    chk($rtoi(t1 - t0 + 0.5) == 20 * n, req, "MDC high time ns", $rtoi(t1 - t0 + 0.5), 20 * n);
    chk($rtoi(t2 - t0 + 0.5) == 40 * n, req, "MDC period ns", $rtoi(t2 - t0 + 0.5), 40 * n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seen_high;
    bit found;
    void'($urandom(32'd2024));
    cyc(4);
    // R1: reset state
    chk(busy === 0 && not_valid === 0 && mdc === 0 && mdio_oe === 0, "R1",
        "idle flags after reset", {busy, not_valid, mdc, mdio_oe}, 0);
    chk(rdata === 16'h0, "R1", "rdata after reset", rdata, 0);
    rst_n = 1'b1;
    measure(3'd7, "R1");  // default select is slowest

    // R2: every select code
    for (int s = 0; s < 8; s++) begin
      cfg_write(0, 0, 3'(s));
      @(negedge mdc);
      measure(3'(s), "R2");
    end

    // R4, R6: write frame with preamble
    cfg_write(0, 0, 3'd0);
    addr_write(5'h15, 5'h0A);
    launch(0, 16'hA5C3);
    finish_frame(0, 5'h15, 5'h0A, 16'hA5C3, 0, "R6");

    // R5, R7: read frame with preamble suppressed
    cfg_write(0, 1, 3'd1);
    phy_word = 16'h3C96;
    addr_write(5'h01, 5'h1F);
    launch(1, 16'h0);
    finish_frame(1, 5'h01, 5'h1F, 16'h0, 1, "R7");

    // R9: commands during a busy frame are ignored
    cfg_write(0, 0, 3'd0);
    addr_write(5'h0C, 5'h03);
    launch(0, 16'h1234);
    data_write(16'hFFFF);
    addr_write(5'h1E, 5'h1E);
    cmd_write(1, 0);
    finish_frame(0, 5'h0C, 5'h03, 16'h1234, 0, "R9");
    phy_word = 16'hBEEF;
    launch(1, 16'h0);
    finish_frame(1, 5'h0C, 5'h03, 16'h0, 0, "R9");

    // R3: management reset
    cfg_write(1, 0, 3'd0);
    cmd_write(1, 0);
    seen_high = 0;
    for (int i = 0; i < 400; i++) begin
      cyc(1);
      if (mdc !== 1'b0 || busy !== 1'b0 || mdio_oe !== 1'b0) seen_high++;
    end
    chk(seen_high == 0, "R3", "cycles with MDC/busy/oe active in mgmt reset", seen_high, 0);
    cfg_write(0, 0, 3'd0);
    cmd_write(1, 0);
    cyc(300);
    chk(busy === 1'b1, "R3", "frame running before abort", busy, 1);
    cfg_write(1, 0, 3'd0);
    cyc(1);
    chk(busy === 1'b0 && mdio_oe === 1'b0, "R3", "abort by mgmt reset", {busy, mdio_oe}, 0);
    cfg_write(0, 0, 3'd0);
    cyc(100);

    // R10: scan
    phy_word = 16'h5A01;
    addr_write(5'h02, 5'h01);
    cmd_write(0, 1);
    chk(busy === 1'b1 && not_valid === 1'b1, "R10", "scan start flags", {busy, not_valid}, 3);
    @(negedge not_valid); #1;
    chk(rdata === 16'h5A01, "R10", "first scan result", rdata, 16'h5A01);
    phy_word = 16'hC3E7;
    found = 0;
    for (int i = 0; i < 3 * 64 * 32 && !found; i++) begin
      cyc(1);
      if (rdata === 16'hC3E7) found = 1;
    end
    chk(found, "R10", "scan repeats and picks up new PHY value", rdata, 16'hC3E7);
    cmd_write(0, 0);
    chk(busy === 1'b1, "R10", "current frame continues after scan clear", busy, 1);
    @(negedge busy); #1;
    chk(rdata === 16'hC3E7, "R10", "last scan frame completes", rdata, 16'hC3E7);
    seen_high = 0;
    for (int i = 0; i < 200; i++) begin
      cyc(1);
      if (busy !== 1'b0) seen_high++;
    end
    chk(seen_high == 0, "R10", "no frame after scan stop", seen_high, 0);

    // Random frames (R4, R5, R6, R7)
    for (int t = 0; t < 10; t++) begin
      bit rd, np;
      logic [4:0] p, r;
      logic [15:0] d;
      logic [2:0] s;
      rd = 1'($urandom);
      np = 1'($urandom);
      p  = 5'($urandom);
      r  = 5'($urandom);
      d  = 16'($urandom);
      s  = 3'($urandom % 4);
      cfg_write(0, np, s);
      addr_write(p, r);
      if (rd) phy_word = d;
      launch(rd, d);
      finish_frame(rd, p, r, d, np, rd ? "R7" : "R6");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule